// File: doc/BRIEF.md
# Time-Triggered Mailbox Transmit Scheduler

This block sits between a set of message mailboxes and a frame transmitter on a bus that runs in time-triggered fashion. It holds a 16-bit window timer that advances on a timer-clock tick. Each mailbox carries a 16-bit time mark. A transmit request that software raises on a mailbox is held back until the timer, sampled on a tick, equals that mailbox's mark. Only then is the frame offered to the transmitter. A frame that loses arbitration waits for the next matching window, or is dropped when the no-retry mode is selected.

The timer is pulled back to zero whenever a frame completes reception in the highest-numbered mailbox, which acts as the reference frame. A software clear pulse also zeroes it. An optional freeze mode parks the timer at FFFFh instead of letting it roll over. An overflow flag marks that the maximum was reached, and a timestamp register records the timer at every frame event.

The transmit sequencer has three states. `S_IDLE` moves to `S_OFFER` when any mailbox is eligible, taking the lowest index. `S_OFFER` moves to `S_BUSY` on `tx_accept_i`. `S_BUSY` returns to `S_IDLE` on `tx_done_i` or on `tx_lost_i`.

Top module: `tt_tx_sched`

## Requirements
- R1: The timer increases by one on each clock cycle in which `tick_i` and `tt_en_i` are both high. In any other cycle, with no clear, it holds its value.
- R2: A one-cycle pulse on `tmr_clr_i` sets the timer to 0 at the next clock edge. This also ends a freeze, so counting resumes on later ticks.
- R3: When `rx_done_i[NMB-1]` is high while `rdy_o[NMB-1]` is 0, the timer becomes 0 and that ready flag is set. Reception into any other mailbox, or into the last mailbox while its ready flag is already 1, leaves the timer alone. Any `rx_done_i[i]` sets `rdy_o[i]`, and `rdy_clr_i[i]` clears it.
- R4: A mailbox's mark is written through `mark_we_i`/`mark_idx_i`/`mark_val_i`. A trigger for that mailbox happens on a tick cycle whose timer value, before the increment, equals the mark. A pending request in `req_o` is never offered before such a trigger.
- R5: After a trigger on a tick cycle, `tx_start_o` rises two clock edges after that tick cycle's edge. It then stays high with a stable `tx_mb_o` until `tx_accept_i` is seen.
- R6: When several mailboxes are eligible at once, the lowest index is offered first. The others are offered in turn without a new trigger.
- R7: `tx_done_i` in the busy state clears the served mailbox's request bit and sets its ready flag.
- R8: On `tx_lost_i` with no-retry off, the request stays set, but the frame is not offered again until the timer next equals its mark on a tick.
- R9: On `tx_lost_i` with `no_retry_i` high, the served mailbox's request bit is cleared.
- R10: With `freeze_en_i` high, the timer stops at FFFFh and does not trigger further comparisons until cleared. With it low, the timer wraps from FFFFh to 0.
- R11: `ovf_o` is set at the edge where the timer reaches FFFFh. It is cleared by a `stat_rd_i` pulse.
- R12: `tstamp_o` loads the timer value on any cycle with a bit of `rx_done_i` high or with a successful `tx_done_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Timer-clock tick |
| tt_en_i | input | 1 | Time-triggered mode enable |
| no_retry_i | input | 1 | Drop frames that lose arbitration |
| freeze_en_i | input | 1 | Stop the timer at its maximum |
| tmr_clr_i | input | 1 | Software timer clear pulse |
| stat_rd_i | input | 1 | Status read pulse, clears overflow |
| mark_we_i | input | 1 | Time mark write strobe |
| mark_idx_i | input | MBW | Mailbox index for mark write |
| mark_val_i | input | TW | Time mark value |
| req_set_i | input | NMB | Per-mailbox transmit request set |
| rx_done_i | input | NMB | Per-mailbox frame received pulse |
| rdy_clr_i | input | NMB | Per-mailbox ready flag clear |
| tx_start_o | output | 1 | Frame offered to transmitter |
| tx_mb_o | output | MBW | Mailbox of the offered frame |
| tx_accept_i | input | 1 | Transmitter took the offer |
| tx_done_i | input | 1 | Frame sent successfully |
| tx_lost_i | input | 1 | Frame lost arbitration |
| timer_o | output | TW | Window timer value |
| ovf_o | output | 1 | Timer reached maximum |
| tstamp_o | output | TW | Timer captured at last frame event |
| req_o | output | NMB | Pending transmit requests |
| rdy_o | output | NMB | Per-mailbox ready flags |

## Verification
A wrong timer value shows at once on `timer_o`. It also shows as a frame offered at the wrong tick, because the bench compares `timer_o` with the mark each time `tx_start_o` rises. A stuck eligibility bit shows within two cycles as a start without a trigger, or as a start that never comes. A bad arbitration order shows as a wrong `tx_mb_o` on the first offer. Broken lost or done handling shows on `req_o` at the edge after the result, and again as an unexpected re-offer during the ticks that follow.

// File: rtl/tt_pkg.sv
package tt_pkg;

    // Transmit sequencer states
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_OFFER = 2'd1,
        S_BUSY  = 2'd2
    } tx_st_e;

endpackage

// File: rtl/tt_timer.sv
module tt_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv_i,
    input  logic          clr_i,
    input  logic          freeze_en_i,
    input  logic          stat_rd_i,
    output logic [TW-1:0] tmr_o,
    output logic          ovf_o,
    output logic          frozen_o
);

    localparam logic [TW-1:0] TMAX = '1;
    localparam logic [TW-1:0] TPRE = TMAX - TW'(1);

    logic [TW-1:0] tmr_q;
    logic          ovf_q;
    logic          step;

    assign frozen_o = freeze_en_i && (tmr_q == TMAX);
    assign step     = adv_i && !frozen_o && !clr_i;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else if (clr_i) begin
            tmr_q <= '0;
        end else if (step) begin
            tmr_q <= tmr_q + TW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_q <= 1'b0;
        end else if (step && (tmr_q == TPRE)) begin
            ovf_q <= 1'b1;
        end else if (stat_rd_i) begin
            ovf_q <= 1'b0;
        end
    end

    assign tmr_o = tmr_q;
    assign ovf_o = ovf_q;

    a_r1_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv_i && !clr_i) |=> (tmr_o == $past(tmr_o)));

    a_r2_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (tmr_o == '0));

    a_r10_freeze_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze_en_i && (tmr_o == TMAX) && !clr_i) |=> (tmr_o == TMAX));

    a_r11_ovf_at_max: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_o) |-> (tmr_o == TMAX));

endmodule

// File: rtl/tt_trig.sv
module tt_trig #(
    parameter  int NMB = 8,
    parameter  int TW  = 16,
    localparam int MBW = (NMB > 1) ? $clog2(NMB) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cmp_en_i,
    input  logic [TW-1:0]  tmr_i,
    input  logic           mark_we_i,
    input  logic [MBW-1:0] mark_idx_i,
    input  logic [TW-1:0]  mark_val_i,
    input  logic [NMB-1:0] req_i,
    input  logic [NMB-1:0] retire_i,
    output logic [NMB-1:0] elig_o
);

    logic [TW-1:0]  mark_q [NMB];
    logic [NMB-1:0] hit;
    logic [NMB-1:0] elig_q;

    for (genvar g = 0; g < NMB; g++) begin : g_mb
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mark_q[g] <= '0;
            end else if (mark_we_i && (mark_idx_i == MBW'(g))) begin
                mark_q[g] <= mark_val_i;
            end
        end

        assign hit[g] = cmp_en_i && (tmr_i == mark_q[g]);

        // A new trigger opens a window; a retire closes it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                elig_q[g] <= 1'b0;
            end else if (hit[g] && req_i[g]) begin
                elig_q[g] <= 1'b1;
            end else if (retire_i[g] || !req_i[g]) begin
                elig_q[g] <= 1'b0;
            end
        end

        a_r4_elig_needs_trigger: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(elig_q[g]) |-> $past(hit[g]));
    end

    assign elig_o = elig_q;

endmodule

// File: rtl/tt_tx_fsm.sv
module tt_tx_fsm
    import tt_pkg::*;
#(
    parameter  int NMB = 8,
    localparam int MBW = (NMB > 1) ? $clog2(NMB) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NMB-1:0] elig_i,
    input  logic           tx_accept_i,
    input  logic           tx_done_i,
    input  logic           tx_lost_i,
    output logic           tx_start_o,
    output logic [MBW-1:0] tx_mb_o,
    output logic           ok_o,
    output logic           lost_o,
    output logic [MBW-1:0] res_mb_o
);

    tx_st_e         st_q, st_d;
    logic [MBW-1:0] sel_q, sel_d;
    logic [MBW-1:0] pick;

    always_comb begin
        pick = '0;
        for (int i = NMB - 1; i >= 0; i--) begin
            if (elig_i[i]) begin
                pick = MBW'(i);
            end
        end
    end

    // Next state and selection
    always_comb begin
        st_d  = st_q;
        sel_d = sel_q;
        unique case (st_q)
            S_IDLE: begin
                if (|elig_i) begin
                    st_d  = S_OFFER;
                    sel_d = pick;
                end
            end
            S_OFFER: begin
                if (tx_accept_i) begin
                    st_d = S_BUSY;
                end
            end
            S_BUSY: begin
                if (tx_done_i || tx_lost_i) begin
                    st_d = S_IDLE;
                end
            end
            default: st_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= S_IDLE;
            sel_q <= '0;
        end else begin
            st_q  <= st_d;
            sel_q <= sel_d;
        end
    end

    // Outputs
    always_comb begin
        tx_start_o = 1'b0;
        ok_o       = 1'b0;
        lost_o     = 1'b0;
        unique case (st_q)
            S_IDLE:  ;
            S_OFFER: tx_start_o = 1'b1;
            S_BUSY: begin
                ok_o   = tx_done_i;
                lost_o = tx_lost_i && !tx_done_i;
            end
            default: ;
        endcase
    end

    assign tx_mb_o  = sel_q;
    assign res_mb_o = sel_q;

    a_r5_offer_held: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_start_o && !tx_accept_i) |=> (tx_start_o && (tx_mb_o == $past(tx_mb_o))));

    a_r6_lowest_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_start_o) |-> ((($past(elig_i)) & ((NMB'(1) << tx_mb_o) - NMB'(1))) == '0));

endmodule

// File: rtl/tt_tx_sched.sv
module tt_tx_sched
    import tt_pkg::*;
#(
    parameter  int NMB = 8,
    parameter  int TW  = 16,
    localparam int MBW = (NMB > 1) ? $clog2(NMB) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick_i,
    input  logic           tt_en_i,
    input  logic           no_retry_i,
    input  logic           freeze_en_i,
    input  logic           tmr_clr_i,
    input  logic           stat_rd_i,
    input  logic           mark_we_i,
    input  logic [MBW-1:0] mark_idx_i,
    input  logic [TW-1:0]  mark_val_i,
    input  logic [NMB-1:0] req_set_i,
    input  logic [NMB-1:0] rx_done_i,
    input  logic [NMB-1:0] rdy_clr_i,
    output logic           tx_start_o,
    output logic [MBW-1:0] tx_mb_o,
    input  logic           tx_accept_i,
    input  logic           tx_done_i,
    input  logic           tx_lost_i,
    output logic [TW-1:0]  timer_o,
    output logic           ovf_o,
    output logic [TW-1:0]  tstamp_o,
    output logic [NMB-1:0] req_o,
    output logic [NMB-1:0] rdy_o
);

    localparam int LAST = NMB - 1;

    logic [NMB-1:0] req_q, rdy_q, elig, retire;
    logic [TW-1:0]  tmr, tstamp_q;
    logic           frozen, ref_sync, adv, ok, lost;
    logic [MBW-1:0] res_mb;

    assign adv      = tick_i && tt_en_i;
    assign ref_sync = rx_done_i[LAST] && !rdy_q[LAST];

    tt_timer #(.TW(TW)) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .adv_i       (adv),
        .clr_i       (tmr_clr_i || ref_sync),
        .freeze_en_i (freeze_en_i),
        .stat_rd_i   (stat_rd_i),
        .tmr_o       (tmr),
        .ovf_o       (ovf_o),
        .frozen_o    (frozen)
    );

    tt_trig #(.NMB(NMB), .TW(TW)) u_trig (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmp_en_i   (adv && !frozen),
        .tmr_i      (tmr),
        .mark_we_i  (mark_we_i),
        .mark_idx_i (mark_idx_i),
        .mark_val_i (mark_val_i),
        .req_i      (req_q),
        .retire_i   (retire),
        .elig_o     (elig)
    );

    tt_tx_fsm #(.NMB(NMB)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .elig_i      (elig),
        .tx_accept_i (tx_accept_i),
        .tx_done_i   (tx_done_i),
        .tx_lost_i   (tx_lost_i),
        .tx_start_o  (tx_start_o),
        .tx_mb_o     (tx_mb_o),
        .ok_o        (ok),
        .lost_o      (lost),
        .res_mb_o    (res_mb)
    );

    for (genvar g = 0; g < NMB; g++) begin : g_mb
        logic hit_me;
        assign hit_me    = (res_mb == MBW'(g));
        assign retire[g] = hit_me && (ok || lost);

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                req_q[g] <= 1'b0;
            end else if (req_set_i[g]) begin
                req_q[g] <= 1'b1;
            end else if (hit_me && (ok || (lost && no_retry_i))) begin
                req_q[g] <= 1'b0;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rdy_q[g] <= 1'b0;
            end else if (rx_done_i[g] || (hit_me && ok)) begin
                rdy_q[g] <= 1'b1;
            end else if (rdy_clr_i[g]) begin
                rdy_q[g] <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tstamp_q <= '0;
        end else if ((|rx_done_i) || ok) begin
            tstamp_q <= tmr;
        end
    end

    assign timer_o  = tmr;
    assign tstamp_o = tstamp_q;
    assign req_o    = req_q;
    assign rdy_o    = rdy_q;

    a_r3_reference_resync: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done_i[LAST] && !rdy_o[LAST]) |=> ((timer_o == '0) && rdy_o[LAST]));

    a_r7_done_retires: assert property (@(posedge clk) disable iff (!rst_n)
        ok |=> (rdy_o[$past(res_mb)] && (!req_o[$past(res_mb)] || $past(req_set_i[res_mb]))));

    a_r9_drop_on_loss: assert property (@(posedge clk) disable iff (!rst_n)
        (lost && no_retry_i && !req_set_i[res_mb]) |=> !req_o[$past(res_mb)]);

    a_r8_keep_on_loss: assert property (@(posedge clk) disable iff (!rst_n)
        (lost && !no_retry_i) |=> req_o[$past(res_mb)]);

endmodule

// File: tb/tb_tt_tx_sched.sv
module tb_tt_tx_sched;

    localparam int NMB = 8;
    localparam int TW  = 16;
    localparam int MBW = 3;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           tick_i, tt_en_i, no_retry_i, freeze_en_i, tmr_clr_i, stat_rd_i;
    logic           mark_we_i;
    logic [MBW-1:0] mark_idx_i;
    logic [TW-1:0]  mark_val_i;
    logic [NMB-1:0] req_set_i, rx_done_i, rdy_clr_i;
    logic           tx_start_o;
    logic [MBW-1:0] tx_mb_o;
    logic           tx_accept_i, tx_done_i, tx_lost_i;
    logic [TW-1:0]  timer_o, tstamp_o;
    logic           ovf_o;
    logic [NMB-1:0] req_o, rdy_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    tt_tx_sched #(.NMB(NMB), .TW(TW)) dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .tt_en_i(tt_en_i),
        .no_retry_i(no_retry_i), .freeze_en_i(freeze_en_i), .tmr_clr_i(tmr_clr_i),
        .stat_rd_i(stat_rd_i), .mark_we_i(mark_we_i), .mark_idx_i(mark_idx_i),
        .mark_val_i(mark_val_i), .req_set_i(req_set_i), .rx_done_i(rx_done_i),
        .rdy_clr_i(rdy_clr_i), .tx_start_o(tx_start_o), .tx_mb_o(tx_mb_o),
        .tx_accept_i(tx_accept_i), .tx_done_i(tx_done_i), .tx_lost_i(tx_lost_i),
        .timer_o(timer_o), .ovf_o(ovf_o), .tstamp_o(tstamp_o), .req_o(req_o),
        .rdy_o(rdy_o)
    );

    task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic tick1();
        tick_i = 1'b1; cyc(1); tick_i = 1'b0;
    endtask

    task automatic ticks(input int n);
        tick_i = 1'b1; cyc(n); tick_i = 1'b0;
    endtask

    task automatic tclr();
        tmr_clr_i = 1'b1; cyc(1); tmr_clr_i = 1'b0;
    endtask

    task automatic set_mark(input int mb, input int val);
        mark_we_i = 1'b1; mark_idx_i = MBW'(mb); mark_val_i = TW'(val);
        cyc(1); mark_we_i = 1'b0;
    endtask

    task automatic set_req(input logic [NMB-1:0] m);
        req_set_i = m; cyc(1); req_set_i = '0;
    endtask

    task automatic rx(input int mb);
        rx_done_i = NMB'(1) << mb; cyc(1); rx_done_i = '0;
    endtask

    // Accept the offer, then report success or loss
    task automatic serve(input bit win);
        tx_accept_i = 1'b1; cyc(1); tx_accept_i = 1'b0;
        if (win) tx_done_i = 1'b1; else tx_lost_i = 1'b1;
        cyc(1);
        tx_done_i = 1'b0; tx_lost_i = 1'b0;
    endtask

    task automatic wait_start(input int lim, output bit seen);
        seen = 0;
        for (int k = 0; k < lim; k++) begin
            if (tx_start_o) begin seen = 1; break; end
            cyc(1);
        end
    endtask

    // Which of two mailboxes (a < b) should be offered first
    function automatic int first_mb(input int a, input int ma, input int b, input int mbk);
        return (ma <= mbk) ? a : b;
    endfunction

    initial begin
        repeat (195000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog: actual running expected done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        bit seen;
        void'($urandom(32'd2024));
        rst_n = 1'b0;
        tick_i = 0; tt_en_i = 0; no_retry_i = 0; freeze_en_i = 0; tmr_clr_i = 0; stat_rd_i = 0;
        mark_we_i = 0; mark_idx_i = '0; mark_val_i = '0;
        req_set_i = '0; rx_done_i = '0; rdy_clr_i = '0;
        tx_accept_i = 0; tx_done_i = 0; tx_lost_i = 0;
        cyc(3);
        rst_n = 1'b1;
        cyc(1);

        // Reset state
        check("R1 reset timer", timer_o, 0);
        check("R11 reset ovf", ovf_o, 0);
        check("R7 reset req/rdy", {req_o, rdy_o}, 0);
        check("R5 reset start", tx_start_o, 0);

        // R1 counting gated by mode
        tt_en_i = 1;
        ticks(5);
        check("R1 count", timer_o, 5);
        tt_en_i = 0; ticks(4);
        check("R1 mode off holds", timer_o, 5);
        tt_en_i = 1; cyc(3);
        check("R1 no tick holds", timer_o, 5);

        // R2 software clear
        tclr();
        check("R2 clear", timer_o, 0);

        // R4/R5/R8/R7 single mailbox
        set_mark(2, 10);
        set_req(8'h04);
        ticks(10);
        cyc(4);
        check("R4 held before mark", tx_start_o, 0);
        check("R4 req pending", req_o, 8'h04);
        tick1();
        check("R5 not yet after one edge", tx_start_o, 0);
        cyc(1);
        check("R5 start on second edge", tx_start_o, 1);
        check("R5 mailbox", tx_mb_o, 2);
        check("R4 timer at offer", timer_o, 11);
        cyc(3);
        check("R5 start held", {tx_start_o, tx_mb_o}, {1'b1, 3'd2});
        serve(0);
        check("R8 pending after loss", req_o, 8'h04);
        ticks(20);
        cyc(3);
        check("R8 no retry in window", tx_start_o, 0);
        tclr();
        ticks(10);
        tick1();
        wait_start(4, seen);
        check("R8 reoffer at next match", {seen, tx_mb_o}, {1'b1, 3'd2});
        serve(1);
        check("R7 req cleared", req_o, 0);
        check("R7 ready set", rdy_o[2], 1);
        check("R12 tstamp at done", tstamp_o, 11);

        // R9 no-retry
        no_retry_i = 1;
        set_mark(4, 3);
        tclr();
        set_req(8'h10);
        ticks(4);
        wait_start(4, seen);
        check("R9 offered", {seen, tx_mb_o}, {1'b1, 3'd4});
        serve(0);
        check("R9 dropped", req_o, 0);
        no_retry_i = 0;

        // R6 same mark, lowest first
        set_mark(1, 6);
        set_mark(5, 6);
        tclr();
        set_req(8'h22);
        ticks(7);
        wait_start(4, seen);
        check("R6 lowest first", {seen, tx_mb_o}, {1'b1, 3'd1});
        serve(1);
        wait_start(4, seen);
        check("R6 second without trigger", {seen, tx_mb_o}, {1'b1, 3'd5});
        serve(1);
        check("R6 all served", req_o, 0);

        // R3 reference resync and R12 timestamp
        tclr();
        ticks(9);
        rx(3);
        check("R12 tstamp at rx", tstamp_o, 9);
        check("R3 other mailbox no reset", timer_o, 9);
        check("R3 ready set", rdy_o[3], 1);
        rx(7);
        check("R3 reference resets", timer_o, 0);
        ticks(5);
        rx(7);
        check("R3 no edge no reset", timer_o, 5);
        rdy_clr_i = 8'h80; cyc(1); rdy_clr_i = '0;
        check("R3 ready cleared", rdy_o[7], 0);
        rx(7);
        check("R3 reference again", timer_o, 0);

        // Random two-mailbox windows
        for (int it = 0; it < 16; it++) begin
            int a, b, ma, mbk, served, fm, sm, fmk, smk;
            a   = $urandom_range(0, 6);
            b   = a + 1 + $urandom_range(0, 6 - a);
            ma  = $urandom_range(2, 25);
            mbk = ($urandom_range(0, 1) == 1) ? ma : $urandom_range(2, 25);
            fm  = first_mb(a, ma, b, mbk);
            sm  = (fm == a) ? b : a;
            fmk = (fm == a) ? ma : mbk;
            smk = (fm == a) ? mbk : ma;
            set_mark(a, ma);
            set_mark(b, mbk);
            tclr();
            set_req((NMB'(1) << a) | (NMB'(1) << b));
            served = 0;
            for (int t = 0; t < 40 && served < 2; t++) begin
                tick1();
                for (int w = 0; w < 4; w++) begin
                    if (tx_start_o) begin
                        check("R6 random order", tx_mb_o, (served == 0) ? fm : sm);
                        check("R4 random window", timer_o, ((served == 0) ? fmk : smk) + 1);
                        serve(1);
                        served++;
                    end else begin
                        cyc(1);
                    end
                end
            end
            check("R4 random both sent", served, 2);
            check("R7 random reqs clear", req_o, 0);
        end

        // R10/R11 freeze at maximum
        freeze_en_i = 1;
        tclr();
        ticks(65535);
        check("R10 reach max", timer_o, 16'hFFFF);
        check("R11 ovf set", ovf_o, 1);
        ticks(20);
        check("R10 frozen", timer_o, 16'hFFFF);
        stat_rd_i = 1; cyc(1); stat_rd_i = 0;
        check("R11 ovf cleared by read", ovf_o, 0);
        tclr();
        ticks(3);
        check("R2 clear unfreezes", timer_o, 3);
        freeze_en_i = 0;
        tclr();
        ticks(65537);
        check("R10 wrap without freeze", timer_o, 1);
        check("R11 ovf on wrap pass", ovf_o, 1);

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule